// File: doc/BRIEF.md
# Serial Bit-Bus Transfer Sequencer

This block is the bus-master side of a one-bit-wide peripheral bus. A peripheral on this bus is reached through a 12-bit bit address, a serial output line with a write strobe, and a serial input line. The block runs five operations: force one bit high, force one bit low, test one bit, load a run of bits from a source word, and store a run of sampled bits into a result word. It moves one bit per bus cycle.

The caller supplies the operation, a base register value, a displacement or bit count byte, and a 16-bit source word, and it pulses `start`. The base register holds the bit address doubled, so its bits 12..1 form the bit address. Single-bit operations add a signed displacement to that address. Multi-bit operations start at the base address and move upward, with addresses wrapping within 12 bits. The block reports completion with a one-cycle `done` pulse. The result word and the equality flag are valid from that pulse on.

Top module: `bitbus_xfer_seq`

## Requirements
- R1: `bit_addr` equals `base_reg[12:1]` for load and store. For set-one, set-zero and test it equals `base_reg[12:1]` plus the sign-extended `disp`, modulo 4096. `addr_lines` always equals `{3'b000, bit_addr, 1'b0}`.
- R2: Op code 0 (set-one) and op code 1 (set-zero) each produce exactly one low pulse on `wstrobe_n`. During that pulse `ser_out` is 1 for set-one and 0 for set-zero.
- R3: Every written bit takes two cycles. In the first cycle address and data are set up with `wstrobe_n` high. In the second cycle `wstrobe_n` is low. Address and data hold the same values in both cycles.
- R4: Op code 2 (test) samples `ser_in` once and copies the sample to `eq_flag`, so that 1 gives a true flag. No other operation changes `eq_flag`.
- R5: Op code 3 (load) writes N bits to ascending consecutive addresses that start at the base address. N is `disp[3:0]`, and the value 0 means 16.
- R6: For a load with N from 1 to 8, the bit written at relative position k is `src_word[8+k]`. For N from 9 to 16 it is `src_word[k]`.
- R7: Op code 4 (store) samples N bits from ascending addresses, with N taken as in R5. For N up to 8, sample k lands in `result[8+k]`. Otherwise it lands in `result[k]`. Every operation clears all `result` bits that receive no sample.
- R8: Each bit that is read has a one-cycle address phase and is sampled at the clock edge that ends it. `wstrobe_n` stays high during reads.
- R9: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R10: A `start` while `busy` is high has no effect. A `start` with an op code of 5, 6 or 7 is ignored.
- R11: After reset `busy`, `done`, `eq_flag`, `ser_out`, `result` and `bit_addr` are 0, and `wstrobe_n` is 1.
- R12: A negative displacement from bit address 0 wraps to the top of the address space. For example, -1 gives 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation code (0 set-one, 1 set-zero, 2 test, 3 load, 4 store) |
| base_reg | input | 16 | Base register, bit address times two |
| disp | input | 8 | Signed displacement (single-bit ops) or count in bits 3..0 (multi-bit ops) |
| src_word | input | 16 | Source word for load |
| ser_in | input | 1 | Serial input line from peripherals |
| addr_lines | output | 16 | Address bus image, bit address in bits 12..1 |
| bit_addr | output | 12 | Current bit address |
| ser_out | output | 1 | Serial output data |
| wstrobe_n | output | 1 | Active-low write strobe |
| result | output | 16 | Assembled store result |
| eq_flag | output | 1 | Test-bit outcome |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the write handshake on every cycle. The strobe is never low for two cycles in a row, address and data hold between setup and strobe, and the address steps by one between consecutive written bits. They also check that the strobe stays high during reads, that `done` is a single-cycle pulse taken only from idle, and that the latched count is in range. Only the bench scenarios can show the bit-level mapping. This covers which source bits reach the bus for short and long loads, where sampled bits land in the result, how displacements and addresses wrap, that `eq_flag` is retained, and that starts issued while busy, or with unused op codes, leave the bus untouched.

// File: rtl/bitbus_pkg.sv
`timescale 1ns/1ps
package bitbus_pkg;

    typedef enum logic [2:0] {
        OP_SET1  = 3'd0,
        OP_SET0  = 3'd1,
        OP_TEST  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } bb_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WSET = 2'd1,
        S_WPUL = 2'd2,
        S_RADR = 2'd3
    } bb_state_e;

endpackage

// File: rtl/bitbus_setup.sv
`timescale 1ns/1ps
// Decodes an operation request into a start address, a bit count, a byte lane and a write word.
module bitbus_setup
    import bitbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    parameter int DISP_W = 8,
    localparam int IDX_W = $clog2(WORD_W),
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] base_reg,
    input  logic [DISP_W-1:0] disp,
    input  logic [WORD_W-1:0] src_word,
    output logic              op_ok,
    output logic              is_write,
    output logic              is_test,
    output logic              is_multi,
    output logic              lane_hi,
    output logic [ADDR_W-1:0] first_addr,
    output logic [CNT_W-1:0]  nbits,
    output logic [WORD_W-1:0] wr_word
);

    logic [ADDR_W-1:0] base_bit;
    logic [ADDR_W-1:0] disp_ext;
    logic [IDX_W-1:0]  cnt_field;

    always_comb begin
        base_bit  = base_reg[ADDR_W:1];
        disp_ext  = ADDR_W'($signed(disp));
        cnt_field = disp[IDX_W-1:0];

        op_ok    = (op == OP_SET1) || (op == OP_SET0) || (op == OP_TEST)
                || (op == OP_LOAD) || (op == OP_STORE);
        is_multi = (op == OP_LOAD) || (op == OP_STORE);
        is_write = (op == OP_SET1) || (op == OP_SET0) || (op == OP_LOAD);
        is_test  = (op == OP_TEST);

        first_addr = is_multi ? base_bit : base_bit + disp_ext;

        if (is_multi) begin
            nbits = (cnt_field == '0) ? CNT_W'(WORD_W) : CNT_W'(cnt_field);
        end else begin
            nbits = CNT_W'(1);
        end
        lane_hi = is_multi && (nbits <= CNT_W'(WORD_W / 2));

        if (op == OP_SET1) begin
            wr_word = '1;
        end else if (op == OP_SET0) begin
            wr_word = '0;
        end else begin
            wr_word = src_word;
        end
    end

endmodule

// File: rtl/bitbus_seq.sv
`timescale 1ns/1ps
// Per-bit bus sequencer: two-cycle write slots, one-cycle read slots.
module bitbus_seq
    import bitbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORD_W),
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_ok,
    input  logic              is_write,
    input  logic              is_test,
    input  logic              lane_hi,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              ser_in,
    output logic [ADDR_W-1:0] bit_addr,
    output logic              ser_out,
    output logic              wstrobe_n,
    output logic [WORD_W-1:0] result,
    output logic              eq_flag,
    output logic              busy,
    output logic              done
);

    localparam logic [IDX_W-1:0] HALF_OFS = IDX_W'(WORD_W / 2);

    typedef struct packed {
        bb_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              dout;
        logic              strobe_n;
        logic [CNT_W-1:0]  left;
        logic [IDX_W-1:0]  idx;
        logic              lane;
        logic              tst;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] res;
        logic              eq;
        logic              done;
    } seq_t;

    seq_t q, d;

    function automatic logic [IDX_W-1:0] lane_pos(input logic [IDX_W-1:0] i, input logic hi);
        return i + (hi ? HALF_OFS : '0);
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start && op_ok) begin
                    d.addr = first_addr;
                    d.left = nbits;
                    d.idx  = '0;
                    d.lane = lane_hi;
                    d.tst  = is_test;
                    d.word = wr_word;
                    d.res  = '0;
                    if (is_write) begin
                        d.st       = S_WSET;
                        d.dout     = wr_word[lane_pos('0, lane_hi)];
                        d.strobe_n = 1'b1;
                    end else begin
                        d.st = S_RADR;
                    end
                end
            end
            S_WSET: begin
                d.st       = S_WPUL;
                d.strobe_n = 1'b0;
            end
            S_WPUL: begin
                d.strobe_n = 1'b1;
                if (q.left == CNT_W'(1)) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.st   = S_WSET;
                    d.left = q.left - 1'b1;
                    d.idx  = q.idx + 1'b1;
                    d.addr = q.addr + 1'b1;
                    d.dout = q.word[lane_pos(q.idx + 1'b1, q.lane)];
                end
            end
            S_RADR: begin
                if (q.tst) begin
                    d.eq = ser_in;
                end else begin
                    d.res[lane_pos(q.idx, q.lane)] = ser_in;
                end
                if (q.left == CNT_W'(1)) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.left = q.left - 1'b1;
                    d.idx  = q.idx + 1'b1;
                    d.addr = q.addr + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.strobe_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign bit_addr  = q.addr;
    assign ser_out   = q.dout;
    assign wstrobe_n = q.strobe_n;
    assign result    = q.res;
    assign eq_flag   = q.eq;
    assign busy      = (q.st != S_IDLE);
    assign done      = q.done;

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !q.strobe_n |=> q.strobe_n);

    assert_setup_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WSET) |=> ($stable(q.addr) && $stable(q.dout)));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WPUL && q.left != CNT_W'(1)) |=> (q.addr == $past(q.addr) + 1'b1));

    assert_read_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RADR) |-> q.strobe_n);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == S_IDLE));

endmodule

// File: rtl/bitbus_xfer_seq.sv
`timescale 1ns/1ps
module bitbus_xfer_seq
    import bitbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] base_reg,
    input  logic [DISP_W-1:0] disp,
    input  logic [WORD_W-1:0] src_word,
    input  logic              ser_in,
    output logic [WORD_W-1:0] addr_lines,
    output logic [ADDR_W-1:0] bit_addr,
    output logic              ser_out,
    output logic              wstrobe_n,
    output logic [WORD_W-1:0] result,
    output logic              eq_flag,
    output logic              busy,
    output logic              done
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int PAD_W = WORD_W - ADDR_W - 1;

    logic              op_ok, is_write, is_test, is_multi, lane_hi;
    logic [ADDR_W-1:0] first_addr;
    logic [CNT_W-1:0]  nbits;
    logic [WORD_W-1:0] wr_word;

    bitbus_setup #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DISP_W(DISP_W)
    ) u_setup (
        .op         (op),
        .base_reg   (base_reg),
        .disp       (disp),
        .src_word   (src_word),
        .op_ok      (op_ok),
        .is_write   (is_write),
        .is_test    (is_test),
        .is_multi   (is_multi),
        .lane_hi    (lane_hi),
        .first_addr (first_addr),
        .nbits      (nbits),
        .wr_word    (wr_word)
    );

    bitbus_seq #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_ok      (op_ok),
        .is_write   (is_write),
        .is_test    (is_test),
        .lane_hi    (lane_hi),
        .first_addr (first_addr),
        .nbits      (nbits),
        .wr_word    (wr_word),
        .ser_in     (ser_in),
        .bit_addr   (bit_addr),
        .ser_out    (ser_out),
        .wstrobe_n  (wstrobe_n),
        .result     (result),
        .eq_flag    (eq_flag),
        .busy       (busy),
        .done       (done)
    );

    assign addr_lines = {{PAD_W{1'b0}}, bit_addr, 1'b0};

    assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_ok && is_multi) |-> (nbits != '0 && nbits <= CNT_W'(WORD_W)));

endmodule

// File: tb/bitbus_xfer_seq_bench.sv
`timescale 1ns/1ps
module bitbus_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [15:0] base_reg = '0;
    logic [7:0]  disp = '0;
    logic [15:0] src_word = '0;
    logic        ser_in;
    logic [15:0] addr_lines;
    logic [11:0] bit_addr;
    logic        ser_out, wstrobe_n, eq_flag, busy, done;
    logic [15:0] result;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic        exp_eq = 1'b0;
    logic [11:0] cur_start = '0;
    logic [15:0] cur_pat = '0;
    logic [11:0] off;

    always #2.5 clk = ~clk;

    bitbus_xfer_seq u_bitbus_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_reg(base_reg),
        .disp(disp), .src_word(src_word), .ser_in(ser_in), .addr_lines(addr_lines),
        .bit_addr(bit_addr), .ser_out(ser_out), .wstrobe_n(wstrobe_n), .result(result),
        .eq_flag(eq_flag), .busy(busy), .done(done)
    );

    // Peripheral model: the input line shows pattern bit k at start address + k.
    always_comb begin
        off    = bit_addr - cur_start;
        ser_in = (off < 12'd16) ? cur_pat[off[3:0]] : 1'b0;
    end

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] base;
        logic [7:0]  disp;
        logic [15:0] src;
        logic [15:0] pat;
        logic [11:0] start;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'h1200, 8'h05, 16'h0000, 16'h0000, 12'h905},
        '{3'd1, 16'h0020, 8'hFE, 16'h0000, 16'h0000, 12'h00E},
        '{3'd0, 16'h0000, 8'hFF, 16'h0000, 16'h0000, 12'hFFF},
        '{3'd2, 16'h0100, 8'h80, 16'h0000, 16'h0000, 12'h000},
        '{3'd2, 16'h0100, 8'h03, 16'h0000, 16'h0001, 12'h083},
        '{3'd3, 16'h1300, 8'h00, 16'hA5C3, 16'h0000, 12'h980},
        '{3'd3, 16'h0040, 8'h05, 16'h3AFF, 16'h0000, 12'h020},
        '{3'd3, 16'h0002, 8'h09, 16'h1234, 16'h0000, 12'h001},
        '{3'd4, 16'h1F00, 8'h08, 16'h0000, 16'h0096, 12'hF80},
        '{3'd4, 16'h1FFE, 8'h00, 16'h0000, 16'hBEEF, 12'hFFF},
        '{3'd4, 16'h0010, 8'hF3, 16'h0000, 16'hFFFF, 12'h008},
        '{3'd4, 16'h0010, 8'h0C, 16'h0000, 16'hFFFF, 12'h008}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int vi, input vec_t v);
        int n, lane, cyc, wcnt;
        bit is_wr, addr_ok, stab_ok, map_ok, seen;
        logic [15:0] exp_w, got_w, exp_r;
        logic [11:0] first_a, prev_a;
        logic prev_sn, prev_o;
        string tag_w;
        is_wr = (v.op == 3'd0) || (v.op == 3'd1) || (v.op == 3'd3);
        n     = (v.op <= 3'd2) ? 1 : ((v.disp[3:0] == 4'd0) ? 16 : int'(v.disp[3:0]));
        lane  = (v.op >= 3'd3 && n <= 8) ? 8 : 0;
        exp_w = '0; exp_r = '0; got_w = '0;
        for (int k = 0; k < n; k++) begin
            if (v.op == 3'd0) exp_w[k] = 1'b1;
            else if (v.op == 3'd3) exp_w[k] = v.src[lane + k];
            if (v.op == 3'd4) exp_r[lane + k] = v.pat[k];
        end
        if (v.op == 3'd2) exp_eq = v.pat[0];
        tag_w = (v.op == 3'd3) ? "R6" : "R2";
        cur_start = v.start;
        cur_pat   = v.pat;
        @(negedge clk);
        op = v.op; base_reg = v.base; disp = v.disp; src_word = v.src; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; wcnt = 0; addr_ok = 1; stab_ok = 1; map_ok = 1; seen = 0;
        first_a = '0; prev_a = '0; prev_sn = 1'b1; prev_o = 1'b0;
        while (!done && cyc < 64) begin
            if (busy) begin
                cyc++;
                if (!seen) begin first_a = bit_addr; seen = 1; end
                if (addr_lines !== {3'b000, bit_addr, 1'b0}) map_ok = 0;
            end
            if (!wstrobe_n) begin
                if (wcnt < 16) got_w[wcnt] = ser_out;
                if (bit_addr !== v.start + 12'(wcnt)) addr_ok = 0;
                if (!(prev_sn === 1'b1 && prev_a === bit_addr && prev_o === ser_out)) stab_ok = 0;
                wcnt++;
            end
            prev_sn = wstrobe_n; prev_a = bit_addr; prev_o = ser_out;
            @(negedge clk);
        end
        $display("vector %0d op %0d", vi, v.op);
        check(done === 1'b1 && busy === 1'b0, "R9", "done with busy low", {busy, done}, 32'h1);
        check(cyc == (is_wr ? 2 * n : n), is_wr ? "R3" : "R8", "busy cycles",
              32'(cyc), 32'(is_wr ? 2 * n : n));
        check(first_a === v.start, "R1,R12", "first bit address", first_a, v.start);
        check(map_ok, "R1", "address line image", addr_lines, {3'b000, bit_addr, 1'b0});
        if (is_wr) begin
            check(wcnt == n, (v.op == 3'd3) ? "R5" : "R2", "strobe pulses", 32'(wcnt), 32'(n));
            check(got_w === exp_w, tag_w, "written bits", got_w, exp_w);
            check(addr_ok, "R5", "ascending write addresses", 32'(addr_ok), 32'h1);
            check(stab_ok, "R3", "setup held into strobe", 32'(stab_ok), 32'h1);
        end else begin
            check(wcnt == 0, "R8", "no strobe on read", 32'(wcnt), 32'h0);
        end
        check(result === exp_r, (v.op == 3'd4) ? "R7" : "R4", "result word", result, exp_r);
        check(eq_flag === exp_eq, "R4", "equality flag", eq_flag, exp_eq);
        @(negedge clk);
        check(done === 1'b0, "R9", "done lasts one cycle", done, 32'h0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int strobes, stray;
        bit addr_in_range;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(busy === 1'b0 && done === 1'b0, "R11", "busy/done after reset", {busy, done}, 32'h0);
        check(wstrobe_n === 1'b1 && ser_out === 1'b0, "R11", "strobe/data after reset",
              {wstrobe_n, ser_out}, 32'h2);
        check(result === 16'h0 && eq_flag === 1'b0 && bit_addr === 12'h0, "R11",
              "result/eq/address after reset", {result, eq_flag, bit_addr}, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R10: start while busy is ignored
        cur_start = 12'h100; cur_pat = '0;
        @(negedge clk);
        op = 3'd3; base_reg = 16'h0200; disp = 8'h04; src_word = 16'hF000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        strobes = 0; addr_in_range = 1;
        for (int c = 0; c < 40 && !done; c++) begin
            if (c == 1) begin
                op = 3'd1; base_reg = 16'h0800; disp = 8'h00; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (!wstrobe_n) begin
                strobes++;
                if (bit_addr < 12'h100 || bit_addr > 12'h103) addr_in_range = 0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(strobes == 4, "R10", "strobes with start during busy", 32'(strobes), 32'h4);
        check(addr_in_range, "R10", "addresses stay in first op", 32'(addr_in_range), 32'h1);
        stray = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (busy || !wstrobe_n) stray++;
        end
        check(stray == 0, "R10", "no activity after ignored start", 32'(stray), 32'h0);
        check(eq_flag === exp_eq, "R4", "eq held across load", eq_flag, exp_eq);

        // R10: unused op code ignored
        op = 3'd6; base_reg = 16'h0444; disp = 8'h01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stray = 0;
        for (int c = 0; c < 5; c++) begin
            if (busy || done || !wstrobe_n) stray++;
            @(negedge clk);
        end
        check(stray == 0, "R10", "unused op code activity", 32'(stray), 32'h0);
        check(result === 16'h0, "R10", "result after unused op", result, 32'h0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule